// File: doc/BRIEF.md
# Transmit Buffer Descriptor Sequencer

This block drives a serial transmitter from a small ring of transmit buffer descriptors kept in local registers. The host writes a descriptor through a single write port. Each descriptor holds five control flags, a byte count and a buffer start address. The sequencer fetches buffer bytes through a one-cycle-latency memory read port and queues them in a byte FIFO. A shifter sends the bytes MSB first, one bit for each `bit_en` strobe. The line sits at all ones whenever no byte is queued.

After the last byte of a buffer has entered the FIFO, the sequencer closes that descriptor. The flags decide what happens next: clear or keep the ready flag, record the end-of-message status, raise an interrupt pulse, move the ring pointer, and either stop on idles or carry straight on into the next buffer. A buffer that is not marked last promises that another one follows. If the next descriptor is not ready at that point, a sticky underrun flag is raised.

The controller has four states:
- `ST_WAIT` loops on idles until the descriptor at the pointer is ready, then goes to `ST_FETCH`.
- `ST_FETCH` issues byte reads while the FIFO has room. Once every byte has landed, it goes to `ST_CLOSE`.
- `ST_CLOSE` updates the descriptor, raises the interrupt and advances the pointer. It goes to `ST_WAIT` for a last buffer and to `ST_NEXT` otherwise.
- `ST_NEXT` goes to `ST_FETCH` if the new descriptor is ready. If it is not ready, it sets the underrun flag and goes to `ST_WAIT`.

Top module: `txbd_sequencer`

## Requirements
- R1: After reset, `ser_out` is 1, `irq_pulse`, `mem_rd_en` and `urun_flag` are 0, and every bit of `desc_ready` and `desc_msg` is 0.
- R2: Whenever the FIFO holds no byte at a bit strobe, the serial output is 1, so an idle line is a continuous run of ones.
- R3: A descriptor with start address A and length N puts the bytes at A, A+1, ..., A+N-1 on the line in that order. Each byte takes 8 bit strobes and goes MSB first.
- R4: Closing a descriptor whose last flag (`host_wr_flags[1]`) is set writes its message status (`desc_msg` bit becomes 1) and clears its ready flag (`host_wr_flags[4]`). The sequencer then sends idles until the descriptor at the pointer is ready.
- R5: Closing a descriptor whose last flag is clear changes only its ready flag (cleared), leaves `desc_msg` at 0, and goes on to the next descriptor without waiting.
- R6: At a descriptor close, `irq_pulse` is high for exactly one cycle with `irq_idx` equal to that descriptor's index, but only if its interrupt flag (`host_wr_flags[2]`) is set.
- R7: When the descriptor reached after a non-last buffer is not ready, `urun_flag` is set. It stays set until a cycle with `urun_clr` high. Closing a last buffer never sets it.
- R8: After an underrun, transmission starts as soon as the descriptor at the pointer becomes ready. No other action is needed.
- R9: Closing a descriptor whose continuous flag (`host_wr_flags[0]`) is set leaves its ready flag set. A lone descriptor with continuous and wrap set resends its buffer again and again until the host writes it with ready clear.
- R10: After a close, the pointer returns to 0 if the wrap flag (`host_wr_flags[3]`) is set or the entry is the highest one. Otherwise it moves to the next entry.
- R11: The FIFO is never written while full, because reads are only issued when the FIFO has room for the byte still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_en | input | 1 | Write one descriptor (all fields, clears its message status) |
| host_wr_idx | input | IDX_W | Descriptor index to write |
| host_wr_flags | input | 5 | {ready, wrap, interrupt, last, continuous} |
| host_wr_len | input | LEN_W | Buffer byte count |
| host_wr_addr | input | ADDR_W | Buffer start address |
| urun_clr | input | 1 | Write-one clear of the underrun flag |
| bit_en | input | 1 | Serial bit strobe |
| mem_rd_en | output | 1 | Buffer byte read request |
| mem_rd_addr | output | ADDR_W | Buffer byte address |
| mem_rd_data | input | 8 | Read data, valid the cycle after the request |
| ser_out | output | 1 | Serial data, MSB first, 1 when idle |
| irq_pulse | output | 1 | One-cycle interrupt at a descriptor close |
| irq_idx | output | IDX_W | Index of the descriptor that raised the interrupt |
| urun_flag | output | 1 | Sticky underrun status |
| desc_ready | output | NDESC | Ready flag of each descriptor |
| desc_msg | output | NDESC | Message-complete status of each descriptor |

## Verification
The bench runs four kinds of stimulus:
- A single last buffer shows the close-and-idle path.
- A non-last buffer chained into a ready last one separates the carry-on path from the stop path, and separates the interrupt being raised from its being suppressed.
- A non-last buffer that wraps onto an empty entry provokes the underrun, idles on the line and then resumes.
- A lone continuous descriptor with wrap set has to loop until its ready flag is withdrawn.

Seeded random rings of four buffers, with random lengths, addresses and interrupt flags, then check the byte order across buffer boundaries and the exact set of interrupts.

// File: rtl/txbd_pkg.sv
package txbd_pkg;
    typedef struct packed {
        logic ready;
        logic wrap;
        logic intr;
        logic last;
        logic cont;
    } txbd_flags_t;

    typedef enum logic [1:0] {
        ST_WAIT,
        ST_FETCH,
        ST_CLOSE,
        ST_NEXT
    } txbd_state_t;
endpackage

// File: rtl/txbd_desc_file.sv
module txbd_desc_file
    import txbd_pkg::*;
#(
    parameter int NDESC  = 4,
    parameter int LEN_W  = 8,
    parameter int ADDR_W = 16,
    localparam int IDX_W = (NDESC > 1) ? $clog2(NDESC) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_wr_en,
    input  logic [IDX_W-1:0]              host_wr_idx,
    input  txbd_flags_t                   host_wr_flags,
    input  logic [LEN_W-1:0]              host_wr_len,
    input  logic [ADDR_W-1:0]             host_wr_addr,
    input  logic                          close_en,
    input  logic [IDX_W-1:0]              close_idx,
    input  logic                          close_last,
    input  logic                          close_cont,
    output txbd_flags_t [NDESC-1:0]       flags_q,
    output logic [NDESC-1:0][LEN_W-1:0]   len_q,
    output logic [NDESC-1:0][ADDR_W-1:0]  addr_q,
    output logic [NDESC-1:0]              msg_q
);
    for (genvar g = 0; g < NDESC; g++) begin : g_entry
        logic hit_wr;
        logic hit_close;
        assign hit_wr    = host_wr_en && (32'(host_wr_idx) == g);
        assign hit_close = close_en && (32'(close_idx) == g);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags_q[g] <= '0;
                len_q[g]   <= '0;
                addr_q[g]  <= '0;
                msg_q[g]   <= 1'b0;
            end else if (hit_wr) begin
                flags_q[g] <= host_wr_flags;
                len_q[g]   <= host_wr_len;
                addr_q[g]  <= host_wr_addr;
                msg_q[g]   <= 1'b0;
            end else if (hit_close) begin
                if (!close_cont) flags_q[g].ready <= 1'b0;
                if (close_last)  msg_q[g]         <= 1'b1;
            end
        end
    end

    assert_close_clears_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (close_en && !close_cont && !host_wr_en) |=> !flags_q[$past(close_idx)].ready);

    assert_cm_keeps_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (close_en && close_cont && !host_wr_en && flags_q[close_idx].ready)
        |=> flags_q[$past(close_idx)].ready);

    assert_last_sets_msg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (close_en && close_last && !host_wr_en) |=> msg_q[$past(close_idx)]);
endmodule

// File: rtl/txbd_byte_fifo.sv
module txbd_byte_fifo #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic [CNT_W-1:0]  count
);
    logic [DEPTH-1:0][DATA_W-1:0] store_q;
    logic [PTR_W-1:0]             wr_ptr_q;
    logic [PTR_W-1:0]             rd_ptr_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    assign empty = (count == '0);
    assign head  = store_q[rd_ptr_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q  <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count    <= '0;
        end else begin
            if (push) begin
                store_q[wr_ptr_q] <= push_data;
                wr_ptr_q          <= bump(wr_ptr_q);
            end
            if (pop && !empty) rd_ptr_q <= bump(rd_ptr_q);
            case ({push, pop && !empty})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (32'(count) < DEPTH));
endmodule

// File: rtl/txbd_shifter.sv
module txbd_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       fifo_empty,
    input  logic [7:0] fifo_head,
    output logic       pop,
    output logic       ser_out
);
    logic [6:0] rest_q;
    logic [2:0] left_q;

    assign pop = bit_en && (left_q == 3'd0) && !fifo_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rest_q  <= '0;
            left_q  <= '0;
            ser_out <= 1'b1;
        end else if (bit_en) begin
            if (left_q != 3'd0) begin
                ser_out <= rest_q[6];
                rest_q  <= {rest_q[5:0], 1'b0};
                left_q  <= left_q - 3'd1;
            end else if (!fifo_empty) begin
                ser_out <= fifo_head[7];
                rest_q  <= fifo_head[6:0];
                left_q  <= 3'd7;
            end else begin
                ser_out <= 1'b1;
            end
        end
    end

    assert_idle_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && left_q == 3'd0 && fifo_empty) |=> ser_out);

    assert_msb_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (ser_out == $past(fifo_head[7])));
endmodule

// File: rtl/txbd_ctrl.sv
module txbd_ctrl
    import txbd_pkg::*;
#(
    parameter int NDESC      = 4,
    parameter int LEN_W      = 8,
    parameter int ADDR_W     = 16,
    parameter int FIFO_DEPTH = 4,
    localparam int IDX_W     = (NDESC > 1) ? $clog2(NDESC) : 1,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  txbd_flags_t       cur_flags,
    input  logic [LEN_W-1:0]  cur_len,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic              urun_clr,
    output logic [IDX_W-1:0]  ptr,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_pend,
    output logic              close_en,
    output logic              close_last,
    output logic              close_cont,
    output logic              irq_pulse,
    output logic              urun_flag
);
    txbd_state_t      state_q, state_d;
    txbd_flags_t      fl_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] issued_q;
    logic [ADDR_W-1:0] base_q;
    logic             load;
    logic             urun_set;
    logic             room;
    logic             all_in;
    logic [IDX_W-1:0] ptr_nxt;

    assign room    = (32'(fifo_count) + 32'(rd_pend)) < FIFO_DEPTH;
    assign all_in  = (issued_q == len_q) && !rd_pend;
    assign ptr_nxt = (fl_q.wrap || 32'(ptr) == NDESC - 1) ? '0 : ptr + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:  if (cur_flags.ready) state_d = ST_FETCH;
            ST_FETCH: if (all_in && !rd_en) state_d = ST_CLOSE;
            ST_CLOSE: state_d = fl_q.last ? ST_WAIT : ST_NEXT;
            ST_NEXT:  state_d = cur_flags.ready ? ST_FETCH : ST_WAIT;
            default:  state_d = ST_WAIT;
        endcase
    end

    // outputs
    always_comb begin
        load       = 1'b0;
        rd_en      = 1'b0;
        close_en   = 1'b0;
        irq_pulse  = 1'b0;
        urun_set   = 1'b0;
        unique case (state_q)
            ST_WAIT:  load = cur_flags.ready;
            ST_FETCH: rd_en = (issued_q != len_q) && room;
            ST_CLOSE: begin
                close_en  = 1'b1;
                irq_pulse = fl_q.intr;
            end
            ST_NEXT: begin
                load     = cur_flags.ready;
                urun_set = !cur_flags.ready;
            end
            default: ;
        endcase
    end

    assign rd_addr    = base_q + ADDR_W'(issued_q);
    assign close_last = fl_q.last;
    assign close_cont = fl_q.cont;

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q      <= '0;
            len_q     <= '0;
            issued_q  <= '0;
            base_q    <= '0;
            rd_pend   <= 1'b0;
            ptr       <= '0;
            urun_flag <= 1'b0;
        end else begin
            rd_pend <= rd_en;
            if (load) begin
                fl_q     <= cur_flags;
                len_q    <= cur_len;
                base_q   <= cur_addr;
                issued_q <= '0;
            end else if (rd_en) begin
                issued_q <= issued_q + 1'b1;
            end
            if (close_en) ptr <= ptr_nxt;
            if (urun_set)      urun_flag <= 1'b1;
            else if (urun_clr) urun_flag <= 1'b0;
        end
    end

    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    assert_urun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (urun_flag && !urun_clr) |=> urun_flag);

    assert_ptr_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (close_en && fl_q.wrap) |=> (ptr == '0));

    assert_fetch_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (issued_q < len_q));
endmodule

// File: rtl/txbd_sequencer.sv
module txbd_sequencer
    import txbd_pkg::*;
#(
    parameter int NDESC      = 4,
    parameter int LEN_W      = 8,
    parameter int ADDR_W     = 16,
    parameter int FIFO_DEPTH = 4,
    localparam int IDX_W     = (NDESC > 1) ? $clog2(NDESC) : 1,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [IDX_W-1:0]  host_wr_idx,
    input  logic [4:0]        host_wr_flags,
    input  logic [LEN_W-1:0]  host_wr_len,
    input  logic [ADDR_W-1:0] host_wr_addr,
    input  logic              urun_clr,
    input  logic              bit_en,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              ser_out,
    output logic              irq_pulse,
    output logic [IDX_W-1:0]  irq_idx,
    output logic              urun_flag,
    output logic [NDESC-1:0]  desc_ready,
    output logic [NDESC-1:0]  desc_msg
);
    txbd_flags_t [NDESC-1:0]        flags_q;
    logic [NDESC-1:0][LEN_W-1:0]    len_q;
    logic [NDESC-1:0][ADDR_W-1:0]   addr_q;
    logic [IDX_W-1:0]               ptr;
    logic                           rd_pend;
    logic                           close_en, close_last, close_cont;
    logic [CNT_W-1:0]               fifo_count;
    logic [7:0]                     fifo_head;
    logic                           fifo_empty, fifo_pop;

    txbd_desc_file #(.NDESC(NDESC), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_descs (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wr_idx(host_wr_idx),
        .host_wr_flags(txbd_flags_t'(host_wr_flags)),
        .host_wr_len(host_wr_len), .host_wr_addr(host_wr_addr),
        .close_en(close_en), .close_idx(ptr),
        .close_last(close_last), .close_cont(close_cont),
        .flags_q(flags_q), .len_q(len_q), .addr_q(addr_q), .msg_q(desc_msg)
    );

    txbd_ctrl #(.NDESC(NDESC), .LEN_W(LEN_W), .ADDR_W(ADDR_W),
                .FIFO_DEPTH(FIFO_DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cur_flags(flags_q[ptr]), .cur_len(len_q[ptr]), .cur_addr(addr_q[ptr]),
        .fifo_count(fifo_count), .urun_clr(urun_clr),
        .ptr(ptr), .rd_en(mem_rd_en), .rd_addr(mem_rd_addr), .rd_pend(rd_pend),
        .close_en(close_en), .close_last(close_last), .close_cont(close_cont),
        .irq_pulse(irq_pulse), .urun_flag(urun_flag)
    );

    txbd_byte_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(8)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(rd_pend), .push_data(mem_rd_data),
        .pop(fifo_pop), .head(fifo_head), .empty(fifo_empty), .count(fifo_count)
    );

    txbd_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .fifo_empty(fifo_empty), .fifo_head(fifo_head),
        .pop(fifo_pop), .ser_out(ser_out)
    );

    assign irq_idx = ptr;

    for (genvar g = 0; g < NDESC; g++) begin : g_rdy
        assign desc_ready[g] = flags_q[g].ready;
    end
endmodule

// File: tb/txbd_sequencer_tb_top.sv
`timescale 1ns/1ps
module txbd_sequencer_tb_top;
    localparam int NDESC = 4;
    localparam int IDX_W = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [1:0]  host_wr_idx = '0;
    logic [4:0]  host_wr_flags = '0;
    logic [7:0]  host_wr_len = '0;
    logic [15:0] host_wr_addr = '0;
    logic        urun_clr = 1'b0;
    logic        bit_en = 1'b1;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic [7:0]  mem_rd_data = '0;
    logic        ser_out, irq_pulse, urun_flag;
    logic [IDX_W-1:0] irq_idx;
    logic [NDESC-1:0] desc_ready, desc_msg;

    int errors = 0;
    int checks = 0;
    logic [7:0] rx_q[$];
    logic [7:0] exp_q[$];
    int irq_q[$];
    bit col_act = 0;
    logic [7:0] col_sh;
    int col_n;
    int zero_cnt = 0;

    always #4 clk = ~clk;

    txbd_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_idx(host_wr_idx),
        .host_wr_flags(host_wr_flags), .host_wr_len(host_wr_len), .host_wr_addr(host_wr_addr),
        .urun_clr(urun_clr), .bit_en(bit_en), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .ser_out(ser_out),
        .irq_pulse(irq_pulse), .irq_idx(irq_idx), .urun_flag(urun_flag),
        .desc_ready(desc_ready), .desc_msg(desc_msg)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        logic [15:0] v;
        v = a * 16'd37 + 16'd11;
        return {1'b0, v[6:0]};
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_byte(mem_rd_addr);

    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_pulse) irq_q.push_back(int'(irq_idx));
            if (!ser_out) zero_cnt++;
            if (col_act) begin
                col_sh = {col_sh[6:0], ser_out};
                col_n++;
                if (col_n == 8) begin
                    rx_q.push_back(col_sh);
                    col_act = 0;
                end
            end else if (!ser_out) begin
                col_act = 1;
                col_sh  = 8'h00;
                col_n   = 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    task automatic wr_desc(input int idx, input bit r, input bit w, input bit i,
                           input bit l, input bit c, input int len, input int addr);
        @(negedge clk);
        host_wr_en    = 1'b1;
        host_wr_idx   = 2'(idx);
        host_wr_flags = {r, w, i, l, c};
        host_wr_len   = 8'(len);
        host_wr_addr  = 16'(addr);
        @(negedge clk);
        host_wr_en    = 1'b0;
    endtask

    task automatic expect_buf(input int addr, input int len);
        for (int k = 0; k < len; k++) exp_q.push_back(mem_byte(16'(addr + k)));
    endtask

    task automatic start_scn();
        @(posedge clk);
        rx_q.delete();
        exp_q.delete();
        irq_q.delete();
    endtask

    task automatic cmp_bytes(input string tag);
        int bad;
        bad = 0;
        chk(rx_q.size() == exp_q.size(), {tag, " byte count"}, rx_q.size(), exp_q.size());
        for (int k = 0; k < rx_q.size() && k < exp_q.size(); k++)
            if (rx_q[k] !== exp_q[k]) begin
                if (bad == 0)
                    chk(0, {tag, " byte value"}, int'(rx_q[k]), int'(exp_q[k]));
                bad++;
            end
        if (bad == 0) chk(1, {tag, " byte value"}, 0, 0);
    endtask

    initial begin
        int total, nirq, lens[4], addrs[4];
        bit ints[4];
        void'($urandom(32'd20240611));
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(ser_out === 1'b1, "R1 ser_out reset", int'(ser_out), 1);
        chk(irq_pulse === 1'b0 && mem_rd_en === 1'b0, "R1 irq/rd reset", int'(irq_pulse), 0);
        chk(urun_flag === 1'b0, "R1 urun reset", int'(urun_flag), 0);
        chk(desc_ready === '0 && desc_msg === '0, "R1 desc reset", int'(desc_ready), 0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        chk(zero_cnt == 0, "R2 idle ones after reset", zero_cnt, 0);

        // single last buffer at entry 0
        start_scn();
        expect_buf(16'h10, 3);
        wr_desc(0, 1, 0, 1, 1, 0, 3, 16'h10);
        repeat (80) @(negedge clk);
        cmp_bytes("R3 single buffer");
        chk(desc_ready[0] == 0, "R4 ready cleared", int'(desc_ready[0]), 0);
        chk(desc_msg[0] == 1, "R4 message status", int'(desc_msg[0]), 1);
        chk(irq_q.size() == 1 && irq_q[0] == 0, "R6 irq single", irq_q.size(), 1);
        zero_cnt = 0;
        repeat (60) @(negedge clk);
        chk(zero_cnt == 0, "R4 idles after last", zero_cnt, 0);

        // chain: entry1 non-last no irq -> entry2 last with irq
        start_scn();
        expect_buf(16'h20, 2);
        expect_buf(16'h30, 4);
        wr_desc(2, 1, 0, 1, 1, 0, 4, 16'h30);
        wr_desc(1, 1, 0, 0, 0, 0, 2, 16'h20);
        repeat (120) @(negedge clk);
        cmp_bytes("R5 chained buffers");
        chk(desc_ready[2:1] == 2'b00, "R5 both ready cleared", int'(desc_ready[2:1]), 0);
        chk(desc_msg[1] == 0, "R5 non-last no status", int'(desc_msg[1]), 0);
        chk(desc_msg[2] == 1, "R4 last status", int'(desc_msg[2]), 1);
        chk(irq_q.size() == 1 && irq_q[0] == 2, "R6 irq only flagged", irq_q.size(), 1);
        chk(urun_flag == 0, "R7 no underrun on chain", int'(urun_flag), 0);

        // underrun: entry3 non-last with wrap, entry0 empty
        start_scn();
        expect_buf(16'h40, 2);
        wr_desc(3, 1, 1, 1, 0, 0, 2, 16'h40);
        repeat (60) @(negedge clk);
        cmp_bytes("R7 underrun buffer");
        chk(urun_flag == 1, "R7 underrun set", int'(urun_flag), 1);
        chk(irq_q.size() == 1 && irq_q[0] == 3, "R6 irq idx3", irq_q.size(), 1);
        zero_cnt = 0;
        repeat (100) @(negedge clk);
        chk(zero_cnt == 0, "R2 idle during underrun", zero_cnt, 0);
        start_scn();
        expect_buf(16'h50, 1);
        wr_desc(0, 1, 0, 0, 1, 0, 1, 16'h50);
        repeat (50) @(negedge clk);
        cmp_bytes("R8 resume at entry0 R10");
        chk(urun_flag == 1, "R7 underrun sticky", int'(urun_flag), 1);
        @(negedge clk); urun_clr = 1'b1;
        @(negedge clk); urun_clr = 1'b0;
        chk(urun_flag == 0, "R7 write-one clear", int'(urun_flag), 0);

        // entry1 with wrap -> pointer back to 0
        start_scn();
        expect_buf(16'h58, 1);
        wr_desc(1, 1, 1, 0, 1, 0, 1, 16'h58);
        repeat (50) @(negedge clk);
        cmp_bytes("R10 wrap entry1");

        // continuous + wrap single descriptor
        start_scn();
        wr_desc(0, 1, 1, 0, 1, 1, 2, 16'h60);
        repeat (300) @(negedge clk);
        chk(desc_ready[0] == 1, "R9 ready kept", int'(desc_ready[0]), 1);
        chk(desc_msg[0] == 1, "R4 cm status", int'(desc_msg[0]), 1);
        wr_desc(0, 0, 1, 0, 1, 1, 2, 16'h60);
        repeat (80) @(negedge clk);
        chk(rx_q.size() >= 12 && rx_q.size() % 2 == 0, "R9 repeats", rx_q.size(), 12);
        for (int k = 0; k < rx_q.size() / 2; k++) expect_buf(16'h60, 2);
        cmp_bytes("R9 repeated content");
        chk(desc_ready[0] == 0, "R9 stopped by host", int'(desc_ready[0]), 0);
        chk(urun_flag == 0, "R7 no underrun after last", int'(urun_flag), 0);

        // random rings starting from entry 0
        for (int it = 0; it < 4; it++) begin
            start_scn();
            total = 0;
            nirq = 0;
            for (int d = 0; d < 4; d++) begin
                lens[d]  = 1 + int'($urandom % 6);
                addrs[d] = int'($urandom % 1024);
                ints[d]  = 1'($urandom % 2);
                total += lens[d];
                nirq += int'(ints[d]);
                expect_buf(16'(addrs[d]), lens[d]);
            end
            for (int d = 3; d >= 0; d--)
                wr_desc(d, 1, d == 3, ints[d], d == 3, 0, lens[d], addrs[d]);
            repeat (8 * total + 100) @(negedge clk);
            cmp_bytes("R3 random ring");
            chk(irq_q.size() == nirq, "R6 random irq count", irq_q.size(), nirq);
            chk(desc_ready == '0, "R5 random ready cleared", int'(desc_ready), 0);
            chk(desc_msg == 4'b1000, "R4 random status", int'(desc_msg), 8);
            chk(urun_flag == 0, "R7 random no underrun", int'(urun_flag), 0);
        end
        finish_run();
    end
endmodule